// File: doc/BRIEF.md
# Sleep Wake-Up and Reset-Cause Controller

This block holds a small microcontroller's low-power sleep state. When the core asks to sleep, the controller marks itself asleep. It then watches for three kinds of wake event: the external reset pin being pulled low, a time-out pulse from the watchdog, and a change on three port input pins. Each event source has its own enable. Any enabled event ends sleep with a full core reset; sleep is never resumed in place. The same event also clears the watchdog.

Change detection does not compare successive samples of the pins. It compares the synchronized pins against a reference captured every time software accesses the port, and once at power-up. Leaving sleep, the block keeps three status bits that let the restarted software tell why it restarted: a time-out bit, a power-down bit and a port-wake flag. The reset it produces is internal. The external reset pin is only ever an input here.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-on reset, `sleeping`, `core_rst` and `wdt_clr` are 0, `st_timeout` is 1, `st_powerdown` is 1 and `st_portwake` is 0. The pin reference holds the pin values present just after reset, so unchanged pins cause no wake.
- R2: A `sleep_req` while awake, with `core_rst` low, sets `sleeping` on the next cycle. The same edge clears `st_powerdown` and sets `st_timeout`. Nothing but power-on reset sets `st_powerdown` again.
- R3: While asleep with `woc_en` = 1, synchronized pins that differ from the reference cause a wake. With `woc_en` = 0 a pin change does not wake.
- R4: While asleep, `wdt_tmo` high with `wdt_en` = 1 causes a wake on the next edge and clears `st_timeout`. With `wdt_en` = 0 the pulse has no effect.
- R5: While asleep with `xrst_en` = 1, a low level on the active-low `xrst_pin_n` causes a wake after its two-flop synchronizer. With `xrst_en` = 0 it has no effect.
- R6: Each wake raises `core_rst` and `wdt_clr` together for exactly one cycle. `sleeping` is 0 in that cycle.
- R7: A wake caused by a pin change sets `st_portwake`. A port access (`port_access` = 1) clears it. Wakes from other sources leave it unchanged.
- R8: A port access loads the reference from the synchronized pins. If the pins already differ from the reference when sleep starts and `woc_en` = 1, the wake follows at once.
- R9: While awake, no input produces `core_rst` or `wdt_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sleep_req | input | 1 | Core requests sleep (one-cycle strobe) |
| xrst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| xrst_en | input | 1 | Pin is configured as a reset input |
| wdt_tmo | input | 1 | Watchdog time-out pulse |
| wdt_en | input | 1 | Watchdog enabled |
| woc_en | input | 1 | Wake on pin change enabled |
| port_pins | input | 3 | Port input pins watched for change, asynchronous |
| port_access | input | 1 | Software file or bit operation on the port |
| core_rst | output | 1 | One-cycle core reset request on wake |
| wdt_clr | output | 1 | One-cycle watchdog clear on wake |
| sleeping | output | 1 | Device is in sleep |
| st_timeout | output | 1 | Time-out status bit, cleared by a watchdog wake |
| st_powerdown | output | 1 | Power-down status bit, cleared on sleep entry |
| st_portwake | output | 1 | Port-wake flag |

## Verification
The assertions check on every cycle:
- the one-cycle pairing of `core_rst` and `wdt_clr`;
- that `sleeping` is low while `core_rst` is high, and that `core_rst` only follows a sleeping cycle;
- the status bit updates on sleep entry, on a watchdog wake and on a port access;
- the reference load that follows each port access.

Only the bench scenarios show the rest:
- each enable gating its own source;
- the synchronizer delay before a pin event is seen;
- that the reference captured at power-up prevents a spurious wake;
- the immediate wake from a stale reference.

// File: rtl/swk_pkg.sv
package swk_pkg;

  typedef struct packed {
    logic ext;
    logic wdt;
    logic chg;
  } wake_src_t;

  function automatic logic any_wake(wake_src_t s);
    return s.ext | s.wdt | s.chg;
  endfunction

  function automatic logic next_timeout(logic cur, logic enter_sleep, logic wake, wake_src_t s);
    logic v;
    v = cur;
    if (enter_sleep) v = 1'b1;
    if (wake && s.wdt) v = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/swk_sync.sv
module swk_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/swk_change_det.sv
module swk_change_det #(
  parameter int W = 3,
  parameter int FILL = 3
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] live,
  input  logic         port_access,
  output logic         moved
);
  localparam int CW = $clog2(FILL + 1);

  logic [CW-1:0] fill_cnt;
  logic          ready;
  logic [W-1:0]  ref_q;
  logic          load;

  function automatic logic differs(logic [W-1:0] a, logic [W-1:0] b);
    return |(a ^ b);
  endfunction

  assign ready = (fill_cnt == CW'(FILL));
  assign load  = port_access | ~ready;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      fill_cnt <= '0;
      ref_q    <= '0;
    end else begin
      if (!ready) fill_cnt <= fill_cnt + 1'b1;
      if (load)   ref_q    <= live;
    end
  end

  assign moved = ready & differs(live, ref_q);

  p_ref_load_r8: assert property (@(posedge clk) disable iff (!por_n)
    port_access |=> (ref_q == $past(live)));
  p_ready_hold_r1: assert property (@(posedge clk) disable iff (!por_n)
    ready |=> ready);
endmodule

// File: rtl/swk_status.sv
module swk_status
  import swk_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  logic      enter_sleep,
  input  logic      wake,
  input  wake_src_t src,
  input  logic      port_access,
  output logic      st_timeout,
  output logic      st_powerdown,
  output logic      st_portwake
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_timeout   <= 1'b1;
      st_powerdown <= 1'b1;
      st_portwake  <= 1'b0;
    end else begin
      st_timeout <= next_timeout(st_timeout, enter_sleep, wake, src);
      if (enter_sleep) st_powerdown <= 1'b0;
      if (wake && src.chg)  st_portwake <= 1'b1;
      else if (port_access) st_portwake <= 1'b0;
    end
  end

  p_pd_sticky_r2: assert property (@(posedge clk) disable iff (!por_n)
    !st_powerdown |=> !st_powerdown);
  p_to_set_r2: assert property (@(posedge clk) disable iff (!por_n)
    enter_sleep |=> st_timeout);
  p_pwf_clear_r7: assert property (@(posedge clk) disable iff (!por_n)
    (port_access && !wake) |=> !st_portwake);
  p_pwf_set_r7: assert property (@(posedge clk) disable iff (!por_n)
    (wake && src.chg) |=> st_portwake);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swk_pkg::*;
#(
  parameter int NPINS = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sleep_req,
  input  logic             xrst_pin_n,
  input  logic             xrst_en,
  input  logic             wdt_tmo,
  input  logic             wdt_en,
  input  logic             woc_en,
  input  logic [NPINS-1:0] port_pins,
  input  logic             port_access,
  output logic             core_rst,
  output logic             wdt_clr,
  output logic             sleeping,
  output logic             st_timeout,
  output logic             st_powerdown,
  output logic             st_portwake
);
  localparam int FILL = SYNC_STAGES + 1;

  logic             xrst_s;
  logic [NPINS-1:0] pins_s;
  logic             moved;
  logic             sleeping_q, rst_q, clr_q;
  logic             enter_sleep, wake;
  wake_src_t        src;

  swk_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_xrst_sync (
    .clk(clk), .por_n(por_n), .d(xrst_pin_n), .q(xrst_s));

  swk_sync #(.W(NPINS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .por_n(por_n), .d(port_pins), .q(pins_s));

  swk_change_det #(.W(NPINS), .FILL(FILL)) u_chg (
    .clk(clk), .por_n(por_n), .live(pins_s), .port_access(port_access), .moved(moved));

  always_comb begin
    src.ext = sleeping_q & xrst_en & ~xrst_s;
    src.wdt = sleeping_q & wdt_en & wdt_tmo;
    src.chg = sleeping_q & woc_en & moved;
  end

  assign wake        = any_wake(src);
  assign enter_sleep = sleep_req & ~sleeping_q & ~rst_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sleeping_q <= 1'b0;
      rst_q      <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      rst_q <= wake;
      clr_q <= wake;
      if (wake)             sleeping_q <= 1'b0;
      else if (enter_sleep) sleeping_q <= 1'b1;
    end
  end

  swk_status u_stat (
    .clk(clk), .por_n(por_n), .enter_sleep(enter_sleep), .wake(wake), .src(src),
    .port_access(port_access), .st_timeout(st_timeout), .st_powerdown(st_powerdown),
    .st_portwake(st_portwake));

  assign core_rst = rst_q;
  assign wdt_clr  = clr_q;
  assign sleeping = sleeping_q;

  p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!por_n)
    core_rst |=> !core_rst);
  p_rst_awake_r6: assert property (@(posedge clk) disable iff (!por_n)
    core_rst |-> !sleeping);
  p_clr_pair_r6: assert property (@(posedge clk) disable iff (!por_n)
    core_rst == wdt_clr);
  p_rst_from_sleep_r9: assert property (@(posedge clk) disable iff (!por_n)
    core_rst |-> $past(sleeping));
  p_pd_on_entry_r2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sleeping) |-> !st_powerdown);
  p_wdt_wake_r4: assert property (@(posedge clk) disable iff (!por_n)
    (sleeping && wdt_en && wdt_tmo) |=> (core_rst && !st_timeout));
endmodule

// File: tb/sim_sleep_wake_ctrl.sv
module sim_sleep_wake_ctrl;
  logic clk = 1'b0, por_n = 1'b0;
  logic sleep_req = 0, xrst_pin_n = 1, xrst_en = 0, wdt_tmo = 0, wdt_en = 0, woc_en = 0;
  logic [2:0] port_pins = 3'b101;
  logic port_access = 0;
  logic core_rst, wdt_clr, sleeping, st_timeout, st_powerdown, st_portwake;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  sleep_wake_ctrl u0 (.*);

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go_sleep();
    sleep_req = 1; cyc(1); sleep_req = 0;
    check(sleeping == 1, "R2", "sleeping after request", sleeping, 1);
    check(st_powerdown == 0, "R2", "powerdown on entry", st_powerdown, 0);
    check(st_timeout == 1, "R2", "timeout on entry", st_timeout, 1);
  endtask

  task automatic expect_wake(input string req);
    int seen = 0;
    for (int i = 0; i < 8 && !seen; i++) begin
      cyc(1);
      if (core_rst) seen = 1;
    end
    check(seen == 1, req, "wake seen", seen, 1);
    if (seen) begin
      check(wdt_clr == 1 && sleeping == 0, "R6", "clr and awake with reset",
            {wdt_clr, sleeping}, 2);
      cyc(1);
      check(core_rst == 0 && wdt_clr == 0, "R6", "one-cycle pulse", {core_rst, wdt_clr}, 0);
    end
  endtask

  task automatic expect_asleep(input string req);
    int hits = 0;
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      if (core_rst || wdt_clr || !sleeping) hits++;
    end
    check(hits == 0, req, "stays asleep", hits, 0);
  endtask

  task automatic t_reset();
    check(!sleeping && !core_rst && !wdt_clr, "R1", "control outputs at reset",
          {sleeping, core_rst, wdt_clr}, 0);
    check(st_timeout && st_powerdown && !st_portwake, "R1", "status at reset",
          {st_timeout, st_powerdown, st_portwake}, 6);
  endtask

  task automatic t_por_ref();
    woc_en = 1;
    go_sleep();
    expect_asleep("R1");
    port_pins = 3'b111;
    expect_wake("R3");
    check(st_portwake == 1, "R7", "port flag after change wake", st_portwake, 1);
    check(st_timeout == 1, "R4", "timeout kept on pin wake", st_timeout, 1);
  endtask

  task automatic t_access();
    port_access = 1; cyc(1); port_access = 0;
    check(st_portwake == 0, "R7", "port flag cleared by access", st_portwake, 0);
  endtask

  task automatic t_wdt();
    woc_en = 0;
    go_sleep();
    port_pins = 3'b011;
    expect_asleep("R3");
    wdt_en = 0; wdt_tmo = 1; cyc(1); wdt_tmo = 0;
    expect_asleep("R4");
    wdt_en = 1; wdt_tmo = 1; cyc(1); wdt_tmo = 0;
    check(core_rst == 1, "R4", "wake one edge after time-out", core_rst, 1);
    check(st_timeout == 0, "R4", "timeout cleared", st_timeout, 0);
    check(st_portwake == 0, "R7", "flag unchanged by watchdog wake", st_portwake, 0);
    cyc(1);
    check(core_rst == 0, "R6", "pulse ends", core_rst, 0);
  endtask

  task automatic t_stale();
    woc_en = 1;
    sleep_req = 1; cyc(1); sleep_req = 0;
    expect_wake("R8");
    check(st_portwake == 1, "R7", "flag on stale wake", st_portwake, 1);
    port_access = 1; cyc(1); port_access = 0;
    go_sleep();
    expect_asleep("R8");
  endtask

  task automatic t_ext();
    xrst_en = 0; xrst_pin_n = 0;
    expect_asleep("R5");
    xrst_pin_n = 1; cyc(3);
    xrst_en = 1; xrst_pin_n = 0;
    expect_wake("R5");
    check(st_portwake == 0 && st_timeout == 1, "R5", "status after pin wake",
          {st_portwake, st_timeout}, 1);
    xrst_pin_n = 1; cyc(3);
  endtask

  task automatic t_awake();
    int hits = 0;
    wdt_en = 1; woc_en = 1; xrst_en = 1;
    wdt_tmo = 1; xrst_pin_n = 0; port_pins = 3'b000;
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      if (core_rst || wdt_clr) hits++;
    end
    wdt_tmo = 0; xrst_pin_n = 1;
    check(hits == 0, "R9", "no reset while awake", hits, 0);
    check(sleeping == 0, "R9", "still awake", sleeping, 0);
  endtask

  initial begin
    cyc(2); por_n = 1; cyc(6);
    t_reset();
    t_por_ref();
    t_access();
    t_wdt();
    t_stale();
    t_ext();
    t_awake();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule